// File: doc/BRIEF.md
# Single-Digit Decimal Subtractor (Nine's-Complement Form)

This block takes two decimal digits coded in 8421 BCD, a minuend X and a subtrahend Y, and returns the magnitude of X − Y as one BCD digit together with a sign flag. It is purely combinational, with no clock and no state. It is meant to sit inside a wider decimal datapath wherever one digit must be compared with or taken from another.

Internally the subtrahend is turned into its nine's complement, 9 − Y. The lowest bit of that complement does not go into the addend. It enters the binary adder as the carry-in, and a zero takes its place in the addend. The five-bit raw sum goes to a correction stage. If the sum carried out of bit 3, or its low nibble is not a legal BCD code, the stage adds 0110 and then adds the end-around carry, which gives a positive difference. Otherwise the raw sum is the nine's-complement image of a negative result, and it is complemented back to a magnitude. A raw sum of exactly 1001 means the operands were equal. That case is reported as zero with a cleared sign, so the block never produces a negative zero.

Top module: `bcd_nines_sub`

## Requirements
- R1: With legal digits (0 to 9) and X > Y, `diff_o` equals X − Y in BCD and `neg_o` is 0.
- R2: With legal digits and X < Y, `diff_o` equals Y − X in BCD and `neg_o` is 1.
- R3: With X equal to Y, `diff_o` is 0000 and `neg_o` is 0.
- R4: A raw sum whose low nibble is 1010 to 1111 takes the add-0110 path with end-around carry, for example 8 − 5 gives `diff_o` 0011 and `neg_o` 0.
- R5: A raw sum that carries out of bit 3 takes the add-0110 path with end-around carry, for example 9 − 1 gives `diff_o` 1000 and `neg_o` 0.
- R6: A raw sum that is a legal code below 1001 with no carry marks a negative result, for example 5 − 8 gives `diff_o` 0011 and `neg_o` 1.
- R7: For every pair of legal digits, `diff_o` is itself a legal BCD digit (0000 to 1001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 4 | Minuend digit, 8421 BCD |
| y_i | input | 4 | Subtrahend digit, 8421 BCD |
| diff_o | output | 4 | Magnitude of X − Y, 8421 BCD |
| neg_o | output | 1 | High when X < Y |

## Verification
Immediate assertions inside the correction stage and the top module are checked whenever the inputs settle. They cover the following: the sign agrees with an integer comparison of the operands, equal operands never give a negative or non-zero result, the magnitude stays a legal digit, and a negative flag only comes with a raw sum below 1001. These assertions cannot show that each correction path gives the right digit, nor that all hundred operand pairs are handled. The bench covers those by sweeping every pair against an integer reference, and it also runs the named cases for the invalid-code, carry-out and negative paths.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;
    localparam int DIGIT_W = 4;
    localparam int RAW_W   = DIGIT_W + 1;
    localparam logic [DIGIT_W-1:0] NINE = 4'd9;
    localparam logic [DIGIT_W-1:0] SIX  = 4'd6;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [RAW_W-1:0]   raw_t;

    typedef struct packed {
        digit_t mag;
        logic   neg;
    } result_t;
endpackage

// File: rtl/bcd_nines_comp.sv
module bcd_nines_comp
    import bcd_sub_pkg::*;
(
    input  digit_t digit_i,
    output digit_t comp_o
);
    digit_t comp_d;

    always_comb begin
        comp_d = NINE - digit_i;
    end

    assign comp_o = comp_d;
endmodule

// File: rtl/bcd_split_adder.sv
module bcd_split_adder
    import bcd_sub_pkg::*;
(
    input  digit_t a_i,
    input  digit_t comp_i,
    output raw_t   sum_o
);
    digit_t addend_d;
    logic   cin_d;
    raw_t   sum_d;

    always_comb begin
        // low complement bit leaves the addend and becomes the carry-in
        addend_d = {comp_i[DIGIT_W-1:1], 1'b0};
        cin_d    = comp_i[0];
        sum_d    = {1'b0, a_i} + {1'b0, addend_d} + {{(RAW_W-1){1'b0}}, cin_d};
    end

    assign sum_o = sum_d;
endmodule

// File: rtl/bcd_fixup.sv
module bcd_fixup
    import bcd_sub_pkg::*;
(
    input  raw_t    raw_i,
    output result_t res_o
);
    logic    pos_d;
    logic    eac_d;
    raw_t    plus6_d;
    digit_t  pos_mag_d;
    result_t res_d;

    always_comb begin
        eac_d     = raw_i[DIGIT_W];
        pos_d     = eac_d | (raw_i[DIGIT_W-1:0] > NINE);
        plus6_d   = {1'b0, raw_i[DIGIT_W-1:0]} + {1'b0, SIX};
        pos_mag_d = plus6_d[DIGIT_W-1:0] + digit_t'(1);
        if (pos_d) begin
            res_d.mag = pos_mag_d;
            res_d.neg = 1'b0;
        end else begin
            res_d.mag = NINE - raw_i[DIGIT_W-1:0];
            res_d.neg = (raw_i[DIGIT_W-1:0] != NINE);
        end
    end

    assign res_o = res_d;

    always_comb begin
        if (raw_i <= raw_t'(18)) begin
            // R6
            neg_below_nine_chk: assert (!res_d.neg || (raw_i < raw_t'(9)))
                else $error("negative flag with raw sum %0d", raw_i);
            // R7
            legal_mag_chk: assert (res_d.mag <= NINE)
                else $error("magnitude %0d not a BCD digit", res_d.mag);
        end
    end
endmodule

// File: rtl/bcd_nines_sub.sv
module bcd_nines_sub
    import bcd_sub_pkg::*;
(
    input  logic [3:0] x_i,
    input  logic [3:0] y_i,
    output logic [3:0] diff_o,
    output logic       neg_o
);
    digit_t  comp_w;
    raw_t    raw_w;
    result_t res_w;

    bcd_nines_comp u_comp (
        .digit_i (y_i),
        .comp_o  (comp_w)
    );

    bcd_split_adder u_add (
        .a_i    (x_i),
        .comp_i (comp_w),
        .sum_o  (raw_w)
    );

    bcd_fixup u_fix (
        .raw_i (raw_w),
        .res_o (res_w)
    );

    assign diff_o = res_w.mag;
    assign neg_o  = res_w.neg;

    always_comb begin
        if ((x_i <= NINE) && (y_i <= NINE)) begin
            // R1 R2
            sign_match_chk: assert (neg_o == (x_i < y_i))
                else $error("sign %0b for %0d-%0d", neg_o, x_i, y_i);
            // R3
            equal_zero_chk: assert ((x_i != y_i) || (!neg_o && diff_o == 4'd0))
                else $error("equal operands gave %0d neg=%0b", diff_o, neg_o);
        end
    end
endmodule

// File: tb/bcd_nines_sub_tb.sv
module bcd_nines_sub_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] x_i, y_i, diff_o;
    logic       neg_o;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    int exp_mag_q[$];
    int exp_neg_q[$];

    bcd_nines_sub u_dut (
        .x_i    (x_i),
        .y_i    (y_i),
        .diff_o (diff_o),
        .neg_o  (neg_o)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (x=%0d y=%0d)", req, what, act, exp, x_i, y_i);
        end
    endtask

    task automatic apply(input int a, input int b, input string req);
        int em, en;
        @(posedge clk);
        #1;
        x_i = 4'(a);
        y_i = 4'(b);
        em = (a >= b) ? a - b : b - a;
        en = (a < b) ? 1 : 0;
        exp_mag_q.push_back(em);
        exp_neg_q.push_back(en);
        @(negedge clk);
        em = exp_mag_q.pop_front();
        en = exp_neg_q.pop_front();
        check(req, int'(diff_o), em, "diff");
        check(req, int'(neg_o), en, "neg");
        check("R7", int'(diff_o <= 4'd9), 1, "legal digit");
    endtask

    initial begin
        x_i = 4'd0;
        y_i = 4'd0;
        // initial state: 0 - 0
        apply(0, 0, "R3");
        // named correction paths
        apply(8, 5, "R4");
        apply(9, 1, "R5");
        apply(5, 8, "R6");
        apply(9, 0, "R5");
        apply(0, 9, "R2");
        // full sweep
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                if (a == b)      apply(a, b, "R3");
                else if (a > b)  apply(a, b, "R1");
                else             apply(a, b, "R2");
            end
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule